// File: doc/BRIEF.md
# Byte-Framed SPI Register Slave

This block is an SPI slave that serves a small file of 8-bit registers. The master talks to it in packets of three bytes: a control byte, a register address byte, and a data byte. Each byte sits in its own active-low select frame. When the select line goes high after a complete byte, the slave moves on to the next byte of the packet. The control byte carries three things: a read/write flag, a broadcast flag, and a 4-bit chain identifier. The identifier is sent bit-reversed and is compared with a local identifier input. A write lands in the register file only when the identifier matches or the broadcast flag is set. A read answers only on a match, by shifting the register out on the serial output during the data byte.

The pins are sampled by a fast system clock through two-flop synchronizers, and edges are found in that clock domain. The serial output comes with a separate output-enable, which the pad uses as a tri-state control. The slave watches for broken framing: a frame cut short, or a frame with too many clock edges. On either error it abandons the packet and ignores traffic until the master resynchronizes. The master resynchronizes by raising the serial clock while select is high; the next framed byte is then taken as a control byte.

Top module: `spirs_top`

## Requirements
- R1: A packet is the control byte, then the address byte, then the data byte. Each byte is 8 bits, MSB first, sampled on 8 rising serial-clock edges while select is low. The rise of select after such a byte advances to the next byte of the packet.
- R2: Control byte fields: bit 7 is broadcast, bit 6 is read (1) or write (0), and bits 5:4 are reserved. Bits 3:0 hold the chain identifier reversed: identifier bit 0 sits in bit 3 and identifier bit 3 sits in bit 0.
- R3: A write commits when the received identifier equals `local_id_i` or broadcast is 1. A read responds only when the identifier equals `local_id_i`; broadcast has no effect on a read.
- R4: `miso_oe_o` is 1 only while select is low during the data byte of a responding read. During that byte, `miso_o` presents the register MSB first and moves to the next bit on each falling serial-clock edge. `miso_o` is 0 whenever `miso_oe_o` is 0.
- R5: A rising serial-clock edge while select is high resets the packet sequence. The next framed byte is taken as a control byte.
- R6: If select rises before the eighth rising edge of a frame, the packet is aborted and the target register is unchanged. Later frames are ignored until a resynchronization (R5).
- R7: If a frame has more than 8 rising edges, it is treated as corrupt. A write in progress is discarded, and later frames are ignored until a resynchronization.
- R8: The file holds 8 registers at addresses 0 to 7. Writes to addresses 8 to 255 change nothing, and reads of those addresses return 0x00.
- R9: If the rise of select and a rising serial-clock edge land in the same synchronized cycle, the resynchronization wins. The byte that just ended is discarded, and the next frame is a control byte.
- R10: After reset, all registers read 0x00, the sequence expects a control byte, and `miso_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master |
| sel_n_i | input | 1 | Active-low select, one frame per byte |
| mosi_i | input | 1 | Serial data from the master |
| local_id_i | input | 4 | Identifier this slave answers to |
| miso_o | output | 1 | Serial read data |
| miso_oe_o | output | 1 | Output enable for the serial data pad |

## Verification
Two events can arrive in the same system-clock cycle: a byte completing on the rise of select, and a resynchronization from a rising serial-clock edge. The bench provokes this by driving select and the serial clock high together at the end of a full data byte of a write. Both pins pass through identical synchronizers, so the two edges reach the logic in the same cycle. The bench then judges the outcome in two ways. A read-back must show the register unchanged. The very next packet, sent with no separate resynchronization, must work, which shows that the sequence restarted at the control byte.

// File: rtl/spirs_pkg.sv
package spirs_pkg;

  typedef enum logic [1:0] {
    PH_CTRL = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_LOST = 2'd3
  } phase_e;

  // bit 7 broadcast, bit 6 read, bits 5:4 reserved, bits 3:0 reversed id
  typedef struct packed {
    logic       bcast;
    logic       rd;
    logic [1:0] rsv;
    logic [3:0] id_rev;
  } ctrl_t;

  function automatic logic [3:0] chain_id(input ctrl_t c);
    return {c.id_rev[0], c.id_rev[1], c.id_rev[2], c.id_rev[3]};
  endfunction

  function automatic logic write_allowed(input ctrl_t c, input logic [3:0] lid);
    return (chain_id(c) == lid) || c.bcast;
  endfunction

  function automatic logic read_allowed(input ctrl_t c, input logic [3:0] lid);
    return chain_id(c) == lid;
  endfunction

endpackage

// File: rtl/spirs_pin_sync.sv
module spirs_pin_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/spirs_byte_rx.sv
module spirs_byte_rx #(
  parameter int DW = 8,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_rise,
  input  logic          sel_n,
  input  logic          sel_rise,
  input  logic          mosi,
  output logic          byte_done,
  output logic          byte_abort,
  output logic          resync,
  output logic [DW-1:0] rx_byte
);
  logic [CW-1:0] cnt;
  logic          ovr;

  assign resync     = sclk_rise & sel_n;
  assign byte_done  = sel_rise & ~resync & (cnt == CW'(DW)) & ~ovr;
  assign byte_abort = sel_rise & ~resync & ~((cnt == CW'(DW)) & ~ovr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      ovr     <= 1'b0;
      rx_byte <= '0;
    end else if (resync || sel_rise) begin
      cnt <= '0;
      ovr <= 1'b0;
    end else if (sclk_rise && !sel_n) begin
      if (cnt == CW'(DW)) begin
        ovr <= 1'b1;
      end else begin
        cnt     <= cnt + 1'b1;
        rx_byte <= {rx_byte[DW-2:0], mosi};
      end
    end
  end

  // R1: every frame outcome clears the bit counter
  p_frame_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done || byte_abort || resync) |=> (cnt == '0));
  // R7: overrun flag only with a full counter
  p_ovr_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> (cnt == CW'(DW)));
endmodule

// File: rtl/spirs_regfile.sv
module spirs_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 8,
  parameter int AW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [NREG-1:0][DW-1:0] mem;

  function automatic logic in_range(input logic [AW-1:0] a);
    return int'(a) < NREG;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (wr_en && in_range(wr_addr)) begin
      mem[IW'(wr_addr)] <= wr_data;
    end
  end

  assign rd_data = in_range(rd_addr) ? mem[IW'(rd_addr)] : '0;

  // R6/R8: contents move only on an accepted write strobe
  p_mem_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem));
endmodule

// File: rtl/spirs_top.sv
module spirs_top #(
  parameter int NREG   = 8,
  parameter int DW     = 8,
  parameter int AW     = 8,
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic       sel_n_i,
  input  logic       mosi_i,
  input  logic [3:0] local_id_i,
  output logic       miso_o,
  output logic       miso_oe_o
);
  import spirs_pkg::*;

  logic [2:0] pin_lvl, pin_rise, pin_fall;
  logic sel_n_s, sclk_rise, sclk_fall, sel_rise, sel_fall, mosi_s;

  spirs_pin_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({sel_n_i, sclk_i, mosi_i}),
    .lvl(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  assign sel_n_s   = pin_lvl[2];
  assign sel_rise  = pin_rise[2];
  assign sel_fall  = pin_fall[2];
  assign sclk_rise = pin_rise[1];
  assign sclk_fall = pin_fall[1];
  assign mosi_s    = pin_lvl[0];

  logic          byte_done, byte_abort, resync;
  logic [DW-1:0] rx_byte;

  spirs_byte_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise(sclk_rise), .sel_n(sel_n_s), .sel_rise(sel_rise),
    .mosi(mosi_s),
    .byte_done(byte_done), .byte_abort(byte_abort), .resync(resync),
    .rx_byte(rx_byte)
  );

  phase_e        phase_q;
  ctrl_t         ctrl_q;
  logic [AW-1:0] addr_q;
  logic          rd_live;
  logic [DW-1:0] tx_q;
  logic          wr_en;
  logic [DW-1:0] rd_data;

  assign wr_en = byte_done && (phase_q == PH_DATA) && !ctrl_q.rd &&
                 write_allowed(ctrl_q, local_id_i);

  spirs_regfile #(.NREG(NREG), .DW(DW), .AW(AW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(addr_q), .wr_data(rx_byte),
    .rd_addr(addr_q), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CTRL;
      ctrl_q  <= '0;
      addr_q  <= '0;
      rd_live <= 1'b0;
    end else if (resync) begin
      phase_q <= PH_CTRL;
      rd_live <= 1'b0;
    end else if (byte_abort) begin
      phase_q <= PH_LOST;
      rd_live <= 1'b0;
    end else if (byte_done) begin
      unique case (phase_q)
        PH_CTRL: begin
          ctrl_q  <= ctrl_t'(rx_byte);
          phase_q <= PH_ADDR;
        end
        PH_ADDR: begin
          addr_q  <= AW'(rx_byte);
          rd_live <= ctrl_q.rd && read_allowed(ctrl_q, local_id_i);
          phase_q <= PH_DATA;
        end
        PH_DATA: begin
          rd_live <= 1'b0;
          phase_q <= PH_CTRL;
        end
        default: phase_q <= PH_LOST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q      <= '0;
      miso_oe_o <= 1'b0;
    end else begin
      if (phase_q == PH_DATA && rd_live && sel_fall)
        tx_q <= rd_data;
      else if (phase_q == PH_DATA && rd_live && !sel_n_s && sclk_fall)
        tx_q <= {tx_q[DW-2:0], 1'b0};
      miso_oe_o <= (phase_q == PH_DATA) && rd_live && !sel_n_s && !resync;
    end
  end

  assign miso_o = miso_oe_o ? tx_q[DW-1] : 1'b0;

  // R4: pad driven only inside the data byte
  p_oe_in_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe_o |-> (phase_q == PH_DATA));
  // R5: resync returns to the control byte
  p_resync_ctrl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (phase_q == PH_CTRL));
  // R6: a broken frame leaves the sequence lost
  p_abort_lost_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_abort |=> (phase_q == PH_LOST));
  // R9: byte completion and resync are never both acted on
  p_single_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_done, byte_abort, resync}));
endmodule

// File: tb/test_spirs_top.sv
`timescale 1ns/1ps
module test_spirs_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sel_n = 1'b1, mosi = 1'b0;
  logic [3:0] lid = 4'd0;
  logic miso, miso_oe;

  spirs_top i_spirs_top (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sel_n_i(sel_n),
    .mosi_i(mosi), .local_id_i(lid), .miso_o(miso), .miso_oe_o(miso_oe)
  );

  always #2 clk = ~clk;

  localparam time H = 24ns;
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] model [8];

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_ctrl(input logic b, input logic r, input logic [3:0] id);
    return {b, r, 2'b00, id[0], id[1], id[2], id[3]};
  endfunction

  task automatic xfer(input logic [7:0] b, input int n, input bit clash,
                      output logic [7:0] rx, output logic oe_any);
    rx = '0; oe_any = 1'b0;
    sel_n = 1'b0; #H;
    for (int i = 0; i < n; i++) begin
      mosi = (i < 8) ? b[7-i] : 1'b0;
      #H;
      rx = {rx[6:0], miso};
      oe_any = oe_any | miso_oe;
      sclk = 1'b1; #H;
      sclk = 1'b0;
    end
    #H;
    if (clash) begin
      sel_n = 1'b1; sclk = 1'b1; #H;
      sclk = 1'b0; #H;
    end else begin
      sel_n = 1'b1; #H;
    end
  endtask

  task automatic resync_pulse();
    sel_n = 1'b1; sclk = 1'b1; #H;
    sclk = 1'b0; #H;
  endtask

  task automatic wr_pkt(input logic b, input logic [3:0] id, input logic [7:0] a,
                        input logic [7:0] d);
    logic [7:0] rx; logic oe;
    xfer(mk_ctrl(b, 1'b0, id), 8, 1'b0, rx, oe);
    xfer(a, 8, 1'b0, rx, oe);
    xfer(d, 8, 1'b0, rx, oe);
    if ((id == lid || b) && a < 8) model[a[2:0]] = d;
  endtask

  task automatic rd_pkt(input logic b, input logic [3:0] id, input logic [7:0] a,
                        output logic [7:0] d, output logic oe_hdr, output logic oe_dat);
    logic [7:0] rx; logic o1, o2;
    xfer(mk_ctrl(b, 1'b1, id), 8, 1'b0, rx, o1);
    xfer(a, 8, 1'b0, rx, o2);
    oe_hdr = o1 | o2;
    xfer(8'h00, 8, 1'b0, d, oe_dat);
  endtask

  task automatic rd_check(input string req, input logic [7:0] a);
    logic [7:0] d; logic oh, od;
    rd_pkt(1'b0, lid, a, d, oh, od);
    chk(req, d, (a < 8) ? model[a[2:0]] : 8'h00);
    chk({req, " hdr oe"}, {7'b0, oh}, 8'h00);
  endtask

  initial begin
    logic [7:0] d, rx; logic oh, od;
    void'($urandom(32'h5eed_0a17));
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10: reset state
    chk("R10 oe after reset", {7'b0, miso_oe}, 8'h00);
    rd_check("R10 reg3 after reset", 8'd3);

    // R1 R4: directed write/read, MSB-first data with pattern bits
    wr_pkt(1'b0, 4'd0, 8'd2, 8'hA5);
    rd_pkt(1'b0, 4'd0, 8'd2, d, oh, od);
    chk("R1 R4 read back reg2", d, 8'hA5);
    chk("R4 oe during data byte", {7'b0, od}, 8'h01);
    chk("R4 no oe in header", {7'b0, oh}, 8'h00);
    chk("R4 oe low after packet", {7'b0, miso_oe}, 8'h00);

    // R2 R3: nonzero local id, reversed id field
    lid = 4'b0001;
    wr_pkt(1'b0, 4'b0001, 8'd5, 8'h3C);
    wr_pkt(1'b0, 4'b1000, 8'd5, 8'hFF);   // bit-reversed alias must not match
    rd_check("R2 reversed id field", 8'd5);
    rd_pkt(1'b1, 4'b0010, 8'd5, d, oh, od);
    chk("R3 unmatched read no oe", {7'b0, od}, 8'h00);
    wr_pkt(1'b1, 4'b0110, 8'd6, 8'h77);   // broadcast write
    rd_check("R3 broadcast write", 8'd6);
    lid = 4'd0;

    // R8: out of range
    wr_pkt(1'b1, 4'd0, 8'd9, 8'h11);
    rd_pkt(1'b0, 4'd0, 8'd9, d, oh, od);
    chk("R8 read addr 9 zero", d, 8'h00);
    chk("R8 read addr 9 oe", {7'b0, od}, 8'h01);
    for (int i = 0; i < 8; i++) rd_check("R8 regs untouched", 8'(i));

    // R6: short data frame, then ignored packet, then resync
    xfer(mk_ctrl(1'b0, 1'b0, 4'd0), 8, 1'b0, rx, oh);
    xfer(8'd2, 8, 1'b0, rx, oh);
    xfer(8'h00, 5, 1'b0, rx, oh);
    xfer(mk_ctrl(1'b0, 1'b0, 4'd0), 8, 1'b0, rx, oh);
    xfer(8'd2, 8, 1'b0, rx, oh);
    xfer(8'h99, 8, 1'b0, rx, oh);
    resync_pulse();
    rd_check("R6 short frame discards", 8'd2);

    // R7: nine edges in data byte
    xfer(mk_ctrl(1'b0, 1'b0, 4'd0), 8, 1'b0, rx, oh);
    xfer(8'd2, 8, 1'b0, rx, oh);
    xfer(8'h42, 9, 1'b0, rx, oh);
    xfer(mk_ctrl(1'b0, 1'b0, 4'd0), 8, 1'b0, rx, oh);
    xfer(8'd2, 8, 1'b0, rx, oh);
    xfer(8'h43, 8, 1'b0, rx, oh);
    resync_pulse();
    rd_check("R7 overrun discards", 8'd2);

    // R5: resync mid-packet, next byte is control
    xfer(mk_ctrl(1'b0, 1'b0, 4'd0), 8, 1'b0, rx, oh);
    resync_pulse();
    wr_pkt(1'b0, 4'd0, 8'd1, 8'h5A);
    rd_check("R5 resync then write", 8'd1);

    // R9: select rise and sclk rise together at end of write data
    xfer(mk_ctrl(1'b0, 1'b0, 4'd0), 8, 1'b0, rx, oh);
    xfer(8'd1, 8, 1'b0, rx, oh);
    xfer(8'hE1, 8, 1'b1, rx, oh);
    rd_check("R9 clash discards byte", 8'd1);
    wr_pkt(1'b0, 4'd0, 8'd7, 8'hC3);
    rd_check("R9 sequence restarted", 8'd7);

    // Random mix (R1 R3 R4 R8)
    for (int k = 0; k < 50; k++) begin
      logic b; logic [3:0] id; logic [7:0] a, v;
      b  = 1'($urandom_range(0, 1));
      id = ($urandom_range(0, 2) == 0) ? 4'($urandom) : lid;
      a  = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'($urandom_range(0, 7));
      v  = 8'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        wr_pkt(b, id, a, v);
      end else begin
        rd_pkt(b, id, a, d, oh, od);
        chk("R3 random read oe", {7'b0, od}, {7'b0, (id == lid)});
        if (id == lid) chk("R4 R8 random read data", d, (a < 8) ? model[a[2:0]] : 8'h00);
      end
    end
    for (int i = 0; i < 8; i++) rd_check("R1 final sweep", 8'(i));

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule